// File: doc/BRIEF.md
# Serial Byte Echo Loopback

This block is a complete asynchronous serial port that runs from a single system clock and sends every byte it receives straight back on its output line. Two counters divide the system clock into clock-enable pulses: one at eight times the bit rate drives the receiver, and one at the bit rate drives the transmitter. The receiver oversamples the incoming line, finds the start of each frame and collects eight data bits into a small synchronous byte queue. The transmitter takes bytes from that queue and sends them as frames.

Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit, with no parity. The line rests high. The host can watch three status flags: queue full, queue empty and a one-cycle pulse when the transmitter has emptied the queue. When the queue still holds data at the end of a frame, the transmitter starts the next frame without going idle, so a burst of received bytes leaves as one continuous stream of frames.

Top module: `uart_echo`

## Requirements
- R1: After synchronous reset, the serial output is high, the queue-empty flag is 1, the queue-full flag is 0 and the done pulse is 0.
- R2: Every byte that is accepted is sent back as a frame on the output: a low start bit, data bits 0 through 7 in that order, and a high stop bit.
- R3: The sample enable occurs once every CLK_HZ/(BAUD*8) system cycles, and the bit enable occurs once every eight of those periods. Each output bit is held for exactly one bit period.
- R4: The receiver leaves idle only after four consecutive synchronised samples are low. A low pulse on the input that lasts two sample periods produces no frame and leaves the queue empty.
- R5: Bytes are sent back in the order they were received. When the queue is not empty at the end of a frame, the next frame follows without the transmitter returning to idle.
- R6: The done output is high for exactly one cycle at the end of each frame after which the queue is empty. This gives one pulse per isolated byte and one pulse per back-to-back burst.
- R7: When the queue holds DEPTH bytes, the full flag is 1 and new bytes are dropped. The bytes that are sent back are an in-order subsequence of the bytes received, with nothing overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial input line (idles high) |
| tx_o | output | 1 | Serial output line (idles high) |
| fifo_full_o | output | 1 | Byte queue holds DEPTH entries |
| fifo_empty_o | output | 1 | Byte queue holds no entries |
| tx_done_o | output | 1 | One-cycle pulse when the transmitter goes idle |

## Verification
The assertions check on every cycle that:
- each enable pulse lasts a single cycle;
- the transmitter state stays one-hot and holds the line high while idle;
- a read never hits an empty queue;
- a write to a full queue never moves the write pointer;
- the receiver only starts after a fully low sample window;
- the done pulse never lasts two cycles.

Only the bench scenarios can show the behaviour at the ports. These scenarios check:
- correct framing, bit order and bit-centre timing of the echoed frames;
- rejection of a short glitch;
- back-to-back chaining of a burst, shown by a single done pulse;
- the dropping of bytes once the queue fills, shown by comparing the echoed stream with the bytes sent.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    localparam int OVERSAMPLE = 8;
    localparam int START_RUN  = 4;

    typedef enum logic [2:0] {
        TX_IDLE = 3'b001,
        TX_LOAD = 3'b010,
        TX_SEND = 3'b100
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic samp;
        logic baud;
    } tick_s;

    function automatic int samp_divisor(input int clk_hz, input int baud);
        return clk_hz / (baud * OVERSAMPLE);
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV = 54
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = (cnt == CW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_spacing
            // R3
            tick_single_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign wr_ok = wr_en && !full;
    assign rd_ok = rd_en && !empty;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) begin
                mem[wr_ptr[AW-1:0]] <= wr_data;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> $stable(wr_ptr));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full) |=> !empty);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_tick,
    input  logic              rx_i,
    output logic              wr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int OW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(DATA_W + 1);

    logic [1:0]           meta;
    logic [START_RUN-1:0] window;
    rx_state_e            state;
    logic [OW-1:0]        phase;
    logic [BW-1:0]        nbits;
    logic [DATA_W-1:0]    shreg;
    logic                 at_centre;

    assign at_centre = (phase == OW'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '1;
            window <= '1;
            state  <= RX_IDLE;
            phase  <= '0;
            nbits  <= '0;
            shreg  <= '0;
        end else begin
            meta <= {meta[0], rx_i};
            if (samp_tick) begin
                window <= {window[START_RUN-2:0], meta[1]};
                case (state)
                    RX_IDLE: begin
                        if (window == '0) begin
                            state <= RX_DATA;
                            phase <= '0;
                            nbits <= '0;
                        end
                    end
                    RX_DATA: begin
                        if (at_centre) begin
                            phase <= '0;
                            if (nbits != BW'(DATA_W)) begin
                                shreg <= {window[0], shreg[DATA_W-1:1]};
                                nbits <= nbits + 1'b1;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign wr_o   = samp_tick && (state == RX_DATA) && at_centre && (nbits == BW'(DATA_W));
    assign data_o = shreg;

    // R4
    rx_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA && $past(state) == RX_IDLE) |-> ($past(window) == '0));

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              rd_o,
    output logic              tx_o,
    output logic              done_o
);
    localparam int CW = $clog2(DATA_W + 2);

    tx_state_e       state;
    logic [DATA_W:0] shreg;
    logic [CW-1:0]   shifts;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '1;
            shifts <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (baud_tick) begin
                case (state)
                    TX_IDLE: begin
                        if (!fifo_empty) state <= TX_LOAD;
                    end
                    TX_LOAD: begin
                        shreg  <= {fifo_data, 1'b0};
                        shifts <= '0;
                        state  <= TX_SEND;
                    end
                    TX_SEND: begin
                        if (shifts != CW'(DATA_W + 1)) begin
                            shreg  <= {1'b1, shreg[DATA_W:1]};
                            shifts <= shifts + 1'b1;
                        end else if (!fifo_empty) begin
                            state <= TX_LOAD;
                        end else begin
                            state  <= TX_IDLE;
                            done_o <= 1'b1;
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    assign rd_o = baud_tick && (state == TX_LOAD);
    assign tx_o = shreg[0];

    // R5
    tx_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> !fifo_empty);
    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> tx_o);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/uart_echo.sv
module uart_echo
    import uart_echo_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic tx_o,
    output logic fifo_full_o,
    output logic fifo_empty_o,
    output logic tx_done_o
);
    localparam int SAMP_DIV = samp_divisor(CLK_HZ, BAUD);
    localparam int BIT_DIV  = SAMP_DIV * OVERSAMPLE;

    tick_s             ticks;
    logic              rx_wr, tx_rd;
    logic [DATA_W-1:0] rx_byte, q_byte;

    uart_tick_gen #(.DIV(SAMP_DIV)) u_samp_tick (
        .clk(clk), .rst(rst), .tick_o(ticks.samp)
    );

    uart_tick_gen #(.DIV(BIT_DIV)) u_baud_tick (
        .clk(clk), .rst(rst), .tick_o(ticks.baud)
    );

    uart_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .samp_tick(ticks.samp), .rx_i(rx_i),
        .wr_o(rx_wr), .data_o(rx_byte)
    );

    uart_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(rx_wr), .wr_data(rx_byte),
        .rd_en(tx_rd), .rd_data(q_byte),
        .full(fifo_full_o), .empty(fifo_empty_o)
    );

    uart_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .baud_tick(ticks.baud),
        .fifo_empty(fifo_empty_o), .fifo_data(q_byte),
        .rd_o(tx_rd), .tx_o(tx_o), .done_o(tx_done_o)
    );

endmodule

// File: tb/test_uart_echo.sv
module test_uart_echo;

    localparam int BITC = 32;   // 800 kHz / 25 kBd, in bench clock cycles
    localparam int DEP  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b1;
    logic tx, full_f, empty_f, done_p;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int frames = 0;
    bit full_seen = 1'b0;
    bit finished = 1'b0;
    logic [7:0] got_q[$];
    logic [7:0] sent_q[$];

    always #5 clk = ~clk;

    uart_echo #(.CLK_HZ(800_000), .BAUD(25_000), .DEPTH(DEP)) i_uart_echo (
        .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx),
        .fifo_full_o(full_f), .fifo_empty_o(empty_f), .tx_done_o(done_p)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && done_p) done_cnt++;
        if (!rst && full_f) full_seen = 1'b1;
    end

    // Output monitor: decodes frames at bit centres (R2, R3)
    initial begin
        logic prev;
        logic [7:0] b;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && prev && !tx) begin
                repeat (BITC / 2) @(negedge clk);
                chk(tx == 1'b0, "R2 start bit", tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = tx;
                end
                repeat (BITC) @(negedge clk);
                chk(tx == 1'b1, "R2 stop bit", tx, 1);
                got_q.push_back(b);
                frames++;
            end
            prev = tx;
        end
    end

    task automatic send_byte(input logic [7:0] b, input int stop_cyc);
        @(negedge clk);
        rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx = 1'b1;
        repeat (stop_cyc) @(negedge clk);
    endtask

    task automatic wait_echo(input int n);
        for (int t = 0; t < 20000 && got_q.size() < n; t++) @(negedge clk);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] dir [4] = '{8'h00, 8'hFF, 8'h55, 8'hA5};
        int d0, f0, j, n_in;
        bit subseq;
        void'($urandom(32'd1234));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx == 1'b1, "R1 tx idle", tx, 1);
        chk(empty_f == 1'b1, "R1 empty", empty_f, 1);
        chk(full_f == 1'b0, "R1 full", full_f, 0);
        chk(done_p == 1'b0, "R1 done", done_p, 0);

        // R2, R6: single bytes, directed then random
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            b = (k < 4) ? dir[k] : 8'($urandom);
            d0 = done_cnt;
            f0 = got_q.size();
            send_byte(b, BITC);
            wait_echo(f0 + 1);
            chk(got_q.size() == f0 + 1, "R2 echo count", got_q.size(), f0 + 1);
            if (got_q.size() > f0) chk(got_q[f0] == b, "R2 echo byte", got_q[f0], b);
            repeat (3 * BITC) @(negedge clk);
            chk(done_cnt - d0 == 1, "R6 done per byte", done_cnt - d0, 1);
        end

        // R4: two-sample glitch is ignored
        f0 = frames;
        @(negedge clk);
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (25 * BITC) @(negedge clk);
        chk(frames == f0, "R4 no frame from glitch", frames, f0);
        chk(empty_f == 1'b1, "R4 queue empty after glitch", empty_f, 1);
        chk(tx == 1'b1, "R4 line high after glitch", tx, 1);

        // R5: burst echoed in order as one chained stream
        d0 = done_cnt;
        f0 = got_q.size();
        sent_q.delete();
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            sent_q.push_back(b);
            send_byte(b, BITC);
        end
        wait_echo(f0 + 8);
        chk(got_q.size() == f0 + 8, "R5 burst count", got_q.size(), f0 + 8);
        for (int k = 0; k < 8 && f0 + k < got_q.size(); k++)
            chk(got_q[f0 + k] == sent_q[k], "R5 burst order", got_q[f0 + k], sent_q[k]);
        repeat (3 * BITC) @(negedge clk);
        chk(done_cnt - d0 == 1, "R5 R6 one done per burst", done_cnt - d0, 1);

        // R7: overfill with short stop bits; drops, never overwrites
        full_seen = 1'b0;
        f0 = got_q.size();
        sent_q.delete();
        n_in = 64;
        for (int k = 0; k < n_in; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            sent_q.push_back(b);
            send_byte(b, BITC - 6);
        end
        for (int t = 0; t < 20000 && !empty_f; t++) @(negedge clk);
        repeat (14 * BITC) @(negedge clk);
        chk(full_seen, "R7 full flag seen", full_seen, 1);
        chk(got_q.size() - f0 < n_in, "R7 bytes dropped", got_q.size() - f0, n_in);
        j = 0;
        subseq = 1'b1;
        for (int k = f0; k < got_q.size(); k++) begin
            while (j < n_in && sent_q[j] != got_q[k]) j++;
            if (j >= n_in) subseq = 1'b0;
            else j++;
        end
        chk(subseq, "R7 in-order subsequence", subseq, 1);
        chk(empty_f && !full_f, "R7 queue drained", {full_f, empty_f}, 1);

        finish_run();
    end

endmodule